// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block takes register traffic from several CPUs and keeps, for each CPU and each of 16 software interrupt IDs, an 8-bit bitmap of the CPUs that raised that interrupt. A CPU raises interrupts with a 32-bit write to a trigger register. The write carries the interrupt ID, an explicit list of targets and a filter mode that can replace that list. Two 16-byte windows let a CPU set or clear requester bits in its own bitmaps directly. A read of either window returns those bitmaps one byte per ID. The block drives one pending flag per (CPU, ID) pair to the prioritisation logic downstream.

Each CPU has its own request port. A fixed-priority arbiter admits one access at a time. A two-state controller sequences each access. In state ST_IDLE the winner of arbitration is accepted; this is the transition ST_IDLE to ST_APPLY, taken whenever any CPU requests. ST_IDLE holds while no CPU requests. In state ST_APPLY the response is driven and the tables are updated at the closing edge. The controller then returns unconditionally to ST_IDLE.

Top module: `sgi_dispatch`

## Requirements
- R1: A 32-bit write at offset 0x00 is a trigger. Bits [3:0] give the ID, bits [23:16] the target list and bits [25:24] the mode. In mode 0 every listed CPU gets the requester's bit set in its bitmap for that ID, and its pending flag is set.
- R2: In mode 1 the target list is ignored, and every CPU below NUM_CPU except the requester is targeted.
- R3: In mode 2 only the requester itself is targeted.
- R4: Mode 3 leaves every bitmap and pending flag unchanged.
- R5: Target-list bits at positions NUM_CPU and above are ignored.
- R6: The set window covers offsets 0x20-0x2F and acts on the requester's own tables. An 8-bit write ORs wdata[7:0] into ID offset[3:0]. A 32-bit write ORs byte lane k into ID {offset[3:2],k}. A pending flag is set only when the resulting bitmap is nonzero.
- R7: The clear window covers offsets 0x10-0x1F, with the same lane-to-ID mapping as R6. It clears the given bits, and a pending flag drops when its bitmap becomes zero.
- R8: A read of either window returns the requester's own bitmaps with the R6 lane mapping. An 8-bit read returns the value in [7:0] with the upper bits zero. Reads of the trigger and of offsets 0x30-0x3F return zero.
- R9: At most one CPU sees req_ready, and only while it requests and the controller is in ST_IDLE. The lowest-indexed requesting CPU wins. rsp_valid is raised for the accepted CPU in the cycle after acceptance, and pending flags change at the end of that cycle.
- R10: Reset clears all bitmaps and pending flags.
- R11: Each pending flag equals the OR of its bitmap at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CPU | Access request, one per CPU |
| req_write | input | NUM_CPU | 1 = write, 0 = read |
| req_word | input | NUM_CPU | 1 = 32-bit access, 0 = 8-bit access |
| req_addr | input | NUM_CPU*6 | Byte offset, 6 bits per CPU |
| req_wdata | input | NUM_CPU*32 | Write data, 32 bits per CPU |
| req_ready | output | NUM_CPU | Request accepted at this edge |
| rsp_valid | output | NUM_CPU | Response cycle for the accepted CPU |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| pend_o | output | NUM_CPU*16 | Pending flag, bit cpu*16+id |

## Verification
The assertions check on every cycle that the controller runs one access at a time. They check that grants are exclusive and go only to requesters, that every acceptance is followed by exactly one response, and that every pending flag matches the OR of its stored bitmap. Only the bench's scenarios can show the rest. That covers the trigger modes and their target sets, the masking of nonexistent CPUs, and the lane-to-ID mapping of the windows for both access sizes. It also covers the read data, the priority order under contention and the reserved mode leaving state untouched. A behavioural model in the bench tracks every bitmap, and the pending outputs are compared with it on every clock.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int NUM_ID    = 16;
    localparam int ID_W      = 4;
    localparam int SRC_W     = 8;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 32;
    localparam int CPU_IDX_W = 3;
    localparam int LANES     = DATA_W / SRC_W;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } disp_state_e;

    typedef enum logic [1:0] {
        RG_TRIG = 2'd0,
        RG_CLR  = 2'd1,
        RG_SET  = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef struct packed {
        logic                 write;
        logic                 word;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    wdata;
        logic [CPU_IDX_W-1:0] who;
    } disp_cmd_t;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        region_e r;
        unique case (a[5:4])
            2'd0:    r = RG_TRIG;
            2'd1:    r = RG_CLR;
            2'd2:    r = RG_SET;
            default: r = RG_NONE;
        endcase
        return r;
    endfunction

    // ID addressed by byte lane 'lane' of a window access
    function automatic logic [ID_W-1:0] lane_id(input logic [ADDR_W-1:0] a,
                                                input logic word, input int lane);
        logic [1:0] l;
        l = lane[1:0];
        return word ? {a[3:2], l} : a[3:0];
    endfunction
endpackage

// File: rtl/sgi_arbiter.sv
module sgi_arbiter
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [NUM_CPU-1:0]   req,
    output logic [NUM_CPU-1:0]   gnt,
    output logic [CPU_IDX_W-1:0] gnt_idx
);
    always_comb begin
        logic found;
        found   = 1'b0;
        gnt     = '0;
        gnt_idx = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (req[c] && !found) begin
                found   = 1'b1;
                gnt[c]  = 1'b1;
                gnt_idx = CPU_IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/sgi_cmd_decode.sv
module sgi_cmd_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int TBL_W  = NUM_CPU * NUM_ID * SRC_W
) (
    input  logic       cmd_valid,
    input  disp_cmd_t  cmd,
    output logic [TBL_W-1:0] set_m,
    output logic [TBL_W-1:0] clr_m
);
    always_comb begin
        logic [ID_W-1:0]    id;
        logic [SRC_W-1:0]   tlist;
        logic [1:0]         mode;
        logic [NUM_CPU-1:0] tgt;
        set_m = '0;
        clr_m = '0;
        id    = cmd.wdata[3:0];
        tlist = cmd.wdata[23:16];
        mode  = cmd.wdata[25:24];
        tgt   = '0;
        if (cmd_valid && cmd.write) begin
            unique case (region_of(cmd.addr))
                RG_TRIG: begin
                    if (cmd.word && cmd.addr[3:0] == 4'd0) begin
                        for (int c = 0; c < NUM_CPU; c++) begin
                            unique case (mode)
                                2'd0:    tgt[c] = tlist[c];
                                2'd1:    tgt[c] = (cmd.who != CPU_IDX_W'(c));
                                2'd2:    tgt[c] = (cmd.who == CPU_IDX_W'(c));
                                default: tgt[c] = 1'b0;
                            endcase
                            if (tgt[c])
                                set_m[(c * NUM_ID + int'(id)) * SRC_W + int'(cmd.who)] = 1'b1;
                        end
                    end
                end
                RG_SET: begin
                    for (int l = 0; l < LANES; l++) begin
                        if (l == 0 || cmd.word)
                            set_m[(int'(cmd.who) * NUM_ID + int'(lane_id(cmd.addr, cmd.word, l))) * SRC_W +: SRC_W]
                                = cmd.wdata[l * SRC_W +: SRC_W];
                    end
                end
                RG_CLR: begin
                    for (int l = 0; l < LANES; l++) begin
                        if (l == 0 || cmd.word)
                            clr_m[(int'(cmd.who) * NUM_ID + int'(lane_id(cmd.addr, cmd.word, l))) * SRC_W +: SRC_W]
                                = cmd.wdata[l * SRC_W +: SRC_W];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sgi_src_table.sv
module sgi_src_table
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int NUM_ENT = NUM_CPU * NUM_ID,
    localparam int TBL_W   = NUM_ENT * SRC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TBL_W-1:0]   set_m,
    input  logic [TBL_W-1:0]   clr_m,
    output logic [TBL_W-1:0]   src_flat,
    output logic [NUM_ENT-1:0] pend_flat
);
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        logic [SRC_W-1:0] src_q;
        logic [SRC_W-1:0] src_d;
        logic             pend_q;
        logic [SRC_W-1:0] set_e;
        logic [SRC_W-1:0] clr_e;

        assign set_e = set_m[e * SRC_W +: SRC_W];
        assign clr_e = clr_m[e * SRC_W +: SRC_W];
        assign src_d = (src_q | set_e) & ~clr_e;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q  <= '0;
                pend_q <= 1'b0;
            end else begin
                src_q <= src_d;
                if (set_e != '0 && src_d != '0)
                    pend_q <= 1'b1;
                else if (clr_e != '0 && src_d == '0)
                    pend_q <= 1'b0;
            end
        end

        assign src_flat[e * SRC_W +: SRC_W] = src_q;
        assign pend_flat[e]                 = pend_q;
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CPU-1:0]        req_valid,
    input  logic [NUM_CPU-1:0]        req_write,
    input  logic [NUM_CPU-1:0]        req_word,
    input  logic [NUM_CPU*ADDR_W-1:0] req_addr,
    input  logic [NUM_CPU*DATA_W-1:0] req_wdata,
    output logic [NUM_CPU-1:0]        req_ready,
    output logic [NUM_CPU-1:0]        rsp_valid,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic [NUM_CPU*NUM_ID-1:0] pend_o
);
    localparam int TBL_W = NUM_CPU * NUM_ID * SRC_W;

    disp_state_e          state_q, state_d;
    disp_cmd_t            cmd_q, cmd_d;
    logic [NUM_CPU-1:0]   gnt;
    logic [CPU_IDX_W-1:0] gnt_idx;
    logic [TBL_W-1:0]     set_m, clr_m, src_flat;

    sgi_arbiter #(.NUM_CPU(NUM_CPU)) u_arb (
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        cmd_d.write = req_write[gnt_idx];
        cmd_d.word  = req_word[gnt_idx];
        cmd_d.addr  = req_addr[int'(gnt_idx) * ADDR_W +: ADDR_W];
        cmd_d.wdata = req_wdata[int'(gnt_idx) * DATA_W +: DATA_W];
        cmd_d.who   = gnt_idx;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (|req_valid) state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && |req_valid)
                cmd_q <= cmd_d;
        end
    end

    // outputs
    always_comb begin
        req_ready = '0;
        rsp_valid = '0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = gnt;
            ST_APPLY: begin
                for (int c = 0; c < NUM_CPU; c++)
                    rsp_valid[c] = (cmd_q.who == CPU_IDX_W'(c));
                if (!cmd_q.write &&
                    (region_of(cmd_q.addr) == RG_SET || region_of(cmd_q.addr) == RG_CLR)) begin
                    for (int l = 0; l < LANES; l++) begin
                        if (l == 0 || cmd_q.word)
                            rsp_rdata[l * SRC_W +: SRC_W] =
                                src_flat[(int'(cmd_q.who) * NUM_ID +
                                          int'(lane_id(cmd_q.addr, cmd_q.word, l))) * SRC_W +: SRC_W];
                    end
                end
            end
            default: ;
        endcase
    end

    sgi_cmd_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .cmd_valid (state_q == ST_APPLY),
        .cmd       (cmd_q),
        .set_m     (set_m),
        .clr_m     (clr_m)
    );

    sgi_src_table #(.NUM_CPU(NUM_CPU)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_m     (set_m),
        .clr_m     (clr_m),
        .src_flat  (src_flat),
        .pend_flat (pend_o)
    );
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CPU-1:0]              req_valid,
    input logic [NUM_CPU-1:0]              req_ready,
    input logic [NUM_CPU-1:0]              rsp_valid,
    input logic [NUM_CPU*NUM_ID-1:0]       pend_o,
    input logic [NUM_CPU*NUM_ID*SRC_W-1:0] src_flat
);
    a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    a_r9_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    a_r9_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid & req_ready)));

    a_r9_no_grant_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_valid) |-> (req_ready == '0));

    for (genvar e = 0; e < NUM_CPU * NUM_ID; e++) begin : g_pend
        a_r11_pend_matches_src: assert property (@(posedge clk) disable iff (!rst_n)
            pend_o[e] == (src_flat[e * SRC_W +: SRC_W] != '0));
    end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .pend_o    (pend_o),
    .src_flat  (src_flat)
);

// File: tb/sim_sgi_dispatch.sv
module sim_sgi_dispatch;
    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N-1:0]    req_write = '0;
    logic [N-1:0]    req_word = '0;
    logic [N*6-1:0]  req_addr = '0;
    logic [N*32-1:0] req_wdata = '0;
    logic [N-1:0]    req_ready;
    logic [N-1:0]    rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [N*16-1:0] pend_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] m_src [N][16];

    always #4 clk = ~clk;

    sgi_dispatch #(.NUM_CPU(N)) u0 (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N*16-1:0] model_pend();
        logic [N*16-1:0] p;
        for (int c = 0; c < N; c++)
            for (int i = 0; i < 16; i++)
                p[c*16+i] = (m_src[c][i] != 8'h00);
        return p;
    endfunction

    function automatic int lid(input logic [5:0] a, input bit word, input int l);
        return word ? (int'(a[3:2]) * 4 + l) : int'(a[3:0]);
    endfunction

    function automatic logic [31:0] model_read(input int c, input bit word, input logic [5:0] a);
        logic [31:0] r = '0;
        if (a[5:4] == 2'd1 || a[5:4] == 2'd2)
            for (int l = 0; l < (word ? 4 : 1); l++)
                r[l*8 +: 8] = m_src[c][lid(a, word, l)];
        return r;
    endfunction

    task automatic model_apply(input int c, input bit word, input logic [5:0] a, input logic [31:0] d);
        if (a == 6'h00 && word) begin
            for (int t = 0; t < N; t++) begin
                bit hit;
                case (d[25:24])
                    2'd0: hit = d[16 + t];
                    2'd1: hit = (t != c);
                    2'd2: hit = (t == c);
                    default: hit = 0;
                endcase
                if (hit) m_src[t][d[3:0]][c] = 1'b1;
            end
        end else if (a[5:4] == 2'd2 || a[5:4] == 2'd1) begin
            for (int l = 0; l < (word ? 4 : 1); l++) begin
                if (a[5:4] == 2'd2) m_src[c][lid(a, word, l)] |= d[l*8 +: 8];
                else                m_src[c][lid(a, word, l)] &= ~d[l*8 +: 8];
            end
        end
    endtask

    // one access from CPU c; read data checked against the model
    task automatic do_op(input int c, input bit wr, input bit word,
                         input logic [5:0] a, input logic [31:0] d, input string req);
        logic [31:0] exp_rd;
        @(negedge clk);
        req_write[c] = wr;
        req_word[c]  = word;
        req_addr[c*6 +: 6]   = a;
        req_wdata[c*32 +: 32] = d;
        req_valid[c] = 1'b1;
        #1;
        while (!req_ready[c]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        exp_rd = model_read(c, word, a);
        @(negedge clk);
        req_valid[c] = 1'b0;
        check(rsp_valid == N'(1 << c), "R9 response", 64'(rsp_valid), 64'(1 << c));
        if (!wr) check(rsp_rdata == exp_rd, req, 64'(rsp_rdata), 64'(exp_rd));
        @(posedge clk);
        #1;
        if (wr) model_apply(c, word, a, d);
    endtask

    // pending outputs compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done)
            check(pend_o == model_pend(), "R11 pending vs model", 64'(pend_o), 64'(model_pend()));
    end

    initial begin
        #800000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N*16-1:0] snap;
        for (int c = 0; c < N; c++)
            for (int i = 0; i < 16; i++)
                m_src[c][i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(pend_o == '0, "R10 reset pending", 64'(pend_o), 64'h0);
        check(req_ready == '0, "R10 reset ready", 64'(req_ready), 64'h0);

        // R1/R5: mode 0 from CPU1, ID5, list bits 0,2,4,5,7
        do_op(1, 1, 1, 6'h00, 32'h00B5_0005, "R1 trigger");
        check(pend_o[0*16+5] && pend_o[2*16+5], "R1 listed pending", 64'(pend_o), 64'h0);
        check(!pend_o[1*16+5] && !pend_o[3*16+5], "R5 unlisted clear", 64'(pend_o), 64'h0);
        do_op(0, 0, 1, 6'h24, 32'h0, "R8 read set window word");
        check(model_read(0, 1, 6'h24) == 32'h0000_0200, "R1 bitmap", 64'(model_read(0, 1, 6'h24)), 64'h200);

        // R2: mode 1 from CPU2, ID9, list ignored
        do_op(2, 1, 1, 6'h00, 32'h0104_0009, "R2 trigger");
        check(pend_o[0*16+9] && pend_o[1*16+9] && pend_o[3*16+9] && !pend_o[2*16+9],
              "R2 all but self", 64'(pend_o), 64'h0);
        do_op(3, 0, 0, 6'h29, 32'h0, "R2 read byte");

        // R3: mode 2 from CPU3, ID15
        do_op(3, 1, 1, 6'h00, 32'h02FF_000F, "R3 trigger");
        check(pend_o[3*16+15] && !pend_o[0*16+15] && !pend_o[1*16+15] && !pend_o[2*16+15],
              "R3 self only", 64'(pend_o), 64'h0);

        // R4: reserved mode
        snap = pend_o;
        do_op(0, 1, 1, 6'h00, 32'h03FF_0003, "R4 trigger");
        check(pend_o == snap, "R4 no change", 64'(pend_o), 64'(snap));
        do_op(0, 0, 1, 6'h20, 32'h0, "R4 read ids 0-3");

        // R6: set window word and byte, zero lane stays clear
        do_op(1, 1, 1, 6'h20, 32'h0080_0011, "R6 set word");
        check(pend_o[1*16+0] && pend_o[1*16+2] && !pend_o[1*16+1], "R6 lanes", 64'(pend_o), 64'h0);
        do_op(1, 1, 0, 6'h2E, 32'h0000_0040, "R6 set byte");
        check(pend_o[1*16+14], "R6 byte id14", 64'(pend_o), 64'h0);
        do_op(1, 0, 1, 6'h2C, 32'h0, "R6 read back ids 12-15");

        // R7: clear window
        do_op(0, 1, 0, 6'h15, 32'h0000_0002, "R7 clear byte");
        check(!pend_o[0*16+5], "R7 pending drops", 64'(pend_o), 64'h0);
        do_op(1, 1, 1, 6'h10, 32'h0000_0001, "R7 partial clear");
        check(pend_o[1*16+0], "R7 partial keeps pending", 64'(pend_o), 64'h0);
        do_op(1, 0, 1, 6'h10, 32'h0, "R8 read clear window");

        // R8: zero reads
        do_op(2, 0, 1, 6'h00, 32'h0, "R8 trigger reads zero");
        do_op(2, 0, 1, 6'h30, 32'h0, "R8 unmapped reads zero");
        do_op(1, 0, 0, 6'h20, 32'h0, "R8 byte read");

        // R9: contention between CPU0 and CPU2
        fork
            do_op(2, 1, 1, 6'h00, 32'h0002_0007, "R9 cpu2");
            do_op(0, 1, 1, 6'h00, 32'h0008_0006, "R9 cpu0");
            begin
                @(negedge clk);
                #2;
                check(req_ready == 4'b0001, "R9 lowest index wins", 64'(req_ready), 64'h1);
            end
        join
        do_op(3, 0, 1, 6'h04, 32'h0, "R9 read unused");
        do_op(1, 0, 1, 6'h24, 32'h0, "R9 read ids 4-7 cpu1");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule